// File: doc/BRIEF.md
# Network Controller Configuration Block Loader

This block fetches the start-up configuration of a network controller from its local 16-bit buffer memory. When software raises the initialization command, the loader takes a 24-bit byte address (the low half from one control register, the top byte from the low byte of a second), and reads twelve consecutive little-endian 16-bit words from that address. It issues one read per cycle over a synchronous memory read port whose data returns one cycle later.

The words are unpacked into the following fields:

- the mode word, whose bit 2 requests internal loopback;
- the 48-bit station address;
- the 64-bit logical address filter;
- a 24-bit base address and a power-of-two entry count for each of the receive and transmit descriptor rings.

All fields are presented together only when the load completes.

At completion the block pulses a done strobe. Neighbouring logic uses this strobe to reset both ring indices to zero and to drop any partly assembled packet. At the same time the block sets a sticky init-done flag and enables the receiver and the transmitter, unless the corresponding mode bit vetoes that.

Top module: `init_block_loader`

## Requirements
- R1: The load start address is {base_hi_i, base_lo_i}, sampled in the cycle the request is accepted; later changes to these inputs do not affect a load in progress.
- R2: A request accepted at a clock edge is followed by exactly 12 reads, one per cycle starting in the next cycle, at addresses start + 2k for k = 0..11.
- R3: misalign_o equals bit 0 of the accepted start address from the cycle after acceptance until the next accepted request; a misaligned start still loads.
- R4: mode_o is word 0 and loopback_o is bit 2 of word 0.
- R5: station_addr_o is {word3, word2, word1} and addr_filter_o is {word7, word6, word5, word4}.
- R6: rx_ring_base_o is {word9[7:0], word8} and tx_ring_base_o is {word11[7:0], word10}; bits 12:8 of words 9 and 11 are ignored.
- R7: rx_ring_len_o is 1 << word9[15:13] and tx_ring_len_o is 1 << word11[15:13], giving 1 to 128 entries.
- R8: After completion rx_on_o = !word0[0] and tx_on_o = !word0[1]. Both are low while a load is in progress, and they change at no other time.
- R9: done_o is a one-cycle pulse two cycles after the last read is issued. busy_o is high from the cycle after acceptance up to, but not including, the done cycle.
- R10: idon_o rises together with done_o, stays high, and clears when the next request is accepted.
- R11: init_req_i while busy_o is high is ignored: the read sequence continues unchanged and only one done pulse follows.
- R12: After reset: busy_o, done_o, idon_o, rx_on_o, tx_on_o, misalign_o and sram_rd_o are low, and both ring lengths are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_req_i | input | 1 | Initialization command |
| base_lo_i | input | 16 | Start address bits 15:0 |
| base_hi_i | input | ADDR_W-16 | Start address upper bits |
| sram_rd_o | output | 1 | Memory read strobe |
| sram_addr_o | output | ADDR_W | Memory byte address |
| sram_rdata_i | input | 16 | Read data, valid one cycle after the strobe |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Completion pulse; ring indices reset, partial packets dropped |
| idon_o | output | 1 | Sticky init-done flag |
| misalign_o | output | 1 | Odd start address flag |
| mode_o | output | 16 | Mode word |
| loopback_o | output | 1 | Internal loopback request |
| station_addr_o | output | 48 | Station address |
| addr_filter_o | output | 64 | Logical address filter |
| rx_ring_base_o | output | 24 | Receive ring base |
| rx_ring_len_o | output | 8 | Receive ring entry count |
| tx_ring_base_o | output | 24 | Transmit ring base |
| tx_ring_len_o | output | 8 | Transmit ring entry count |
| rx_on_o | output | 1 | Receiver enable |
| tx_on_o | output | 1 | Transmitter enable |

## Verification
A wrong word counter or a wrong state shows up at once on the read port: a skipped, repeated or extra address appears within the twelve read cycles. A misplaced capture index does not appear until the done cycle, as one field holding a neighbouring word's data. The sweep gives every word a distinct value and varies both ring codes and both veto bits over all their values, so a swapped field, a swapped ring or an inverted enable is visible in the first load that exercises it. Ignored mid-load requests are exposed by the address sequence and by an idle window after completion.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 12;
  localparam int CODE_W    = 3;
  localparam int LEN_W     = 1 << CODE_W;
  localparam int RING_AW   = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DONE} st_e;

  typedef struct packed {
    logic [RING_AW-1:0] base;
    logic [LEN_W-1:0]   len;
  } ring_t;

  // lo: base bits 15:0; hi: base bits 23:16 in [7:0], log2 count in [15:13]
  function automatic ring_t ring_decode(input logic [WORD_W-1:0] lo,
                                        input logic [WORD_W-1:0] hi);
    ring_t r;
    r.base = {hi[7:0], lo};
    r.len  = LEN_W'(1) << hi[WORD_W-1 -: CODE_W];
    return r;
  endfunction
endpackage

// File: rtl/ibl_seq.sv
module ibl_seq #(
  parameter int ADDR_W    = 24,
  parameter int NUM_WORDS = 12,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cap_vld_o,
  output logic [IDX_W-1:0]  cap_idx_o,
  output logic              busy_o,
  output logic              last_o
);
  import ibl_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  st_e               state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              cap_vld_q;
  logic [IDX_W-1:0]  cap_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= base_i;
          cnt_q   <= '0;
          state_q <= ST_READ;
        end
        ST_READ: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // data returns one cycle after the read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_vld_q <= (state_q == ST_READ);
      cap_idx_q <= cnt_q;
    end
  end

  assign rd_o      = (state_q == ST_READ);
  assign addr_o    = base_q + ADDR_W'({cnt_q, 1'b0});
  assign cap_vld_o = cap_vld_q;
  assign cap_idx_o = cap_idx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign last_o    = (state_q == ST_DONE);
endmodule

// File: rtl/ibl_fields.sv
module ibl_fields #(
  parameter int NUM_WORDS = 12,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cap_vld_i,
  input  logic [IDX_W-1:0]           cap_idx_i,
  input  logic [ibl_pkg::WORD_W-1:0] rdata_i,
  input  logic                       commit_i,
  output logic [1:0]                 veto_nx_o,
  output logic [ibl_pkg::WORD_W-1:0] mode_o,
  output logic [47:0]                station_o,
  output logic [63:0]                filter_o,
  output ibl_pkg::ring_t             rx_ring_o,
  output ibl_pkg::ring_t             tx_ring_o
);
  import ibl_pkg::*;

  logic [WORD_W-1:0] stage_q [NUM_WORDS];
  logic [WORD_W-1:0] word_nx [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic hit;
    assign hit        = cap_vld_i && (cap_idx_i == IDX_W'(i));
    assign word_nx[i] = hit ? rdata_i : stage_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  stage_q[i] <= '0;
      else if (hit) stage_q[i] <= rdata_i;
    end
  end

  assign veto_nx_o = word_nx[0][1:0];

  // everything becomes visible together at commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= '0;
      station_o <= '0;
      filter_o  <= '0;
      rx_ring_o <= ring_decode('0, '0);
      tx_ring_o <= ring_decode('0, '0);
    end else if (commit_i) begin
      mode_o    <= word_nx[0];
      station_o <= {word_nx[3], word_nx[2], word_nx[1]};
      filter_o  <= {word_nx[7], word_nx[6], word_nx[5], word_nx[4]};
      rx_ring_o <= ring_decode(word_nx[8], word_nx[9]);
      tx_ring_o <= ring_decode(word_nx[10], word_nx[11]);
    end
  end
endmodule

// File: rtl/ibl_ctrl.sv
module ibl_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       base_lsb_i,
  input  logic       commit_i,
  input  logic [1:0] veto_i,
  output logic       done_o,
  output logic       idon_o,
  output logic       misalign_o,
  output logic       rx_on_o,
  output logic       tx_on_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      idon_o     <= 1'b0;
      misalign_o <= 1'b0;
      rx_on_o    <= 1'b0;
      tx_on_o    <= 1'b0;
    end else begin
      done_o <= commit_i;
      if (start_i) begin
        idon_o     <= 1'b0;
        misalign_o <= base_lsb_i;
        rx_on_o    <= 1'b0;
        tx_on_o    <= 1'b0;
      end else if (commit_i) begin
        idon_o  <= 1'b1;
        rx_on_o <= ~veto_i[0];
        tx_on_o <= ~veto_i[1];
      end
    end
  end
endmodule

// File: rtl/init_block_loader.sv
module init_block_loader #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_req_i,
  input  logic [15:0]       base_lo_i,
  input  logic [ADDR_W-17:0] base_hi_i,
  output logic              sram_rd_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  input  logic [15:0]       sram_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              idon_o,
  output logic              misalign_o,
  output logic [15:0]       mode_o,
  output logic              loopback_o,
  output logic [47:0]       station_addr_o,
  output logic [63:0]       addr_filter_o,
  output logic [23:0]       rx_ring_base_o,
  output logic [7:0]        rx_ring_len_o,
  output logic [23:0]       tx_ring_base_o,
  output logic [7:0]        tx_ring_len_o,
  output logic              rx_on_o,
  output logic              tx_on_o
);
  import ibl_pkg::*;

  localparam int IDX_W = $clog2(NUM_WORDS);

  logic              start;
  logic [ADDR_W-1:0] base;
  logic              cap_vld;
  logic [IDX_W-1:0]  cap_idx;
  logic              commit;
  logic [1:0]        veto_nx;
  ring_t             rx_ring, tx_ring;

  assign base  = {base_hi_i, base_lo_i};
  assign start = init_req_i && !busy_o;

  ibl_seq #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .start_i  (start),
    .base_i   (base),
    .rd_o     (sram_rd_o),
    .addr_o   (sram_addr_o),
    .cap_vld_o(cap_vld),
    .cap_idx_o(cap_idx),
    .busy_o   (busy_o),
    .last_o   (commit)
  );

  ibl_fields #(.NUM_WORDS(NUM_WORDS)) u_fields (
    .clk_i, .rst_ni,
    .cap_vld_i(cap_vld),
    .cap_idx_i(cap_idx),
    .rdata_i  (sram_rdata_i),
    .commit_i (commit),
    .veto_nx_o(veto_nx),
    .mode_o   (mode_o),
    .station_o(station_addr_o),
    .filter_o (addr_filter_o),
    .rx_ring_o(rx_ring),
    .tx_ring_o(tx_ring)
  );

  ibl_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .start_i   (start),
    .base_lsb_i(base[0]),
    .commit_i  (commit),
    .veto_i    (veto_nx),
    .done_o    (done_o),
    .idon_o    (idon_o),
    .misalign_o(misalign_o),
    .rx_on_o   (rx_on_o),
    .tx_on_o   (tx_on_o)
  );

  assign loopback_o     = mode_o[2];
  assign rx_ring_base_o = rx_ring.base;
  assign rx_ring_len_o  = rx_ring.len;
  assign tx_ring_base_o = tx_ring.base;
  assign tx_ring_len_o  = tx_ring.len;
endmodule

// File: rtl/init_block_loader_chk.sv
module init_block_loader_chk #(
  parameter int ADDR_W    = 24,
  parameter int NUM_WORDS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sram_rd_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              idon_o,
  input logic              rx_on_o,
  input logic              tx_on_o,
  input logic [7:0]        rx_ring_len_o,
  input logic [7:0]        tx_ring_len_o
);
  logic       past_vld;
  logic [7:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_vld <= 1'b0;
      rd_cnt   <= '0;
    end else begin
      past_vld <= 1'b1;
      rd_cnt   <= done_o ? 8'(sram_rd_o) : rd_cnt + 8'(sram_rd_o);
    end
  end

  p_rd_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_rd_o |-> busy_o);
  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld && sram_rd_o && $past(sram_rd_o) |-> sram_addr_o == $past(sram_addr_o) + ADDR_W'(2));
  p_rd_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_cnt == 8'(NUM_WORDS));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld && done_o |-> !busy_o && $past(busy_o));
  p_idon_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idon_o);
  p_on_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld && !done_o && !busy_o |-> $stable(rx_on_o) && $stable(tx_on_o));
  p_len_pow2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rx_ring_len_o) == 1 && $countones(tx_ring_len_o) == 1);
endmodule

bind init_block_loader init_block_loader_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(ibl_pkg::NUM_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sram_rd_o(sram_rd_o), .sram_addr_o(sram_addr_o),
  .busy_o(busy_o), .done_o(done_o), .idon_o(idon_o), .rx_on_o(rx_on_o), .tx_on_o(tx_on_o),
  .rx_ring_len_o(rx_ring_len_o), .tx_ring_len_o(tx_ring_len_o)
);

// File: tb/init_block_loader_tb.sv
module init_block_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        init_req = 0;
  logic [15:0] base_lo = 0;
  logic [7:0]  base_hi = 0;
  logic        sram_rd;
  logic [23:0] sram_addr;
  logic [15:0] sram_rdata = 0;
  logic        busy, done, idon, misalign, loopback, rx_on, tx_on;
  logic [15:0] mode;
  logic [47:0] station;
  logic [63:0] filter;
  logic [23:0] rx_base, tx_base;
  logic [7:0]  rx_len, tx_len;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] words [12];
  logic [23:0] cur_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_block_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req),
    .base_lo_i(base_lo), .base_hi_i(base_hi),
    .sram_rd_o(sram_rd), .sram_addr_o(sram_addr), .sram_rdata_i(sram_rdata),
    .busy_o(busy), .done_o(done), .idon_o(idon), .misalign_o(misalign),
    .mode_o(mode), .loopback_o(loopback), .station_addr_o(station),
    .addr_filter_o(filter), .rx_ring_base_o(rx_base), .rx_ring_len_o(rx_len),
    .tx_ring_base_o(tx_base), .tx_ring_len_o(tx_len), .rx_on_o(rx_on), .tx_on_o(tx_on)
  );

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    logic [23:0] off;
    off = a - cur_base;
    if (off < 24) return words[off[4:1]];
    return ~a[15:0];
  endfunction

  always @(posedge clk) if (sram_rd) sram_rdata <= mem_word(sram_addr);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int r);
    words[0] = 16'(r & 7);
    for (int i = 1; i < 8; i++) words[i] = 16'(16'h1111 * i + r * 16'h0203);
    words[8]  = 16'h1234 + 16'(r);
    words[9]  = {3'(r), 5'b10101, 8'h40 + 8'(r)};
    words[10] = 16'hbeef - 16'(r);
    words[11] = {3'(7 - r), 5'b01010, 8'h80 + 8'(r)};
  endtask

  task automatic run_load(input logic [23:0] base, input bit inject);
    int n_rd = 0;
    int done_it = -1;
    cur_base = base;
    base_lo = base[15:0];
    base_hi = base[23:16];
    init_req = 1;
    @(negedge clk);
    init_req = 0;
    for (int it = 0; it < 40; it++) begin
      if (it == 0) begin
        chk(busy == 1, "R9 busy after accept", 64'(busy), 64'd1);
        chk(idon == 0, "R10 idon cleared on accept", 64'(idon), 64'd0);
        chk(rx_on == 0 && tx_on == 0, "R8 enables low while loading", {rx_on, tx_on}, 64'd0);
      end
      if (it == 1) chk(misalign == base[0], "R3 misalign flag", 64'(misalign), 64'(base[0]));
      if (inject && it == 4) begin
        init_req = 1;
        base_lo = base[15:0] + 16'h0100;
        base_hi = base[23:16] ^ 8'h5a;
      end
      if (inject && it == 5) init_req = 0;
      if (sram_rd) begin
        chk(sram_addr == base + 24'(2 * n_rd), "R1 R2 R11 read address", 64'(sram_addr), 64'(base + 24'(2 * n_rd)));
        n_rd++;
      end
      if (done) begin
        done_it = it;
        break;
      end
      @(negedge clk);
    end
    chk(n_rd == 12, "R2 read count", 64'(n_rd), 64'd12);
    chk(done_it == 13, "R9 done timing", 64'(done_it), 64'd13);
    chk(busy == 0, "R9 busy low at done", 64'(busy), 64'd0);
    chk(idon == 1, "R10 idon set", 64'(idon), 64'd1);
    chk(mode == words[0], "R4 mode", 64'(mode), 64'(words[0]));
    chk(loopback == words[0][2], "R4 loopback", 64'(loopback), 64'(words[0][2]));
    chk(station == {words[3], words[2], words[1]}, "R5 station", 64'(station), 64'({words[3], words[2], words[1]}));
    chk(filter == {words[7], words[6], words[5], words[4]}, "R5 filter", filter, {words[7], words[6], words[5], words[4]});
    chk(rx_base == {words[9][7:0], words[8]}, "R6 rx base", 64'(rx_base), 64'({words[9][7:0], words[8]}));
    chk(tx_base == {words[11][7:0], words[10]}, "R6 tx base", 64'(tx_base), 64'({words[11][7:0], words[10]}));
    chk(rx_len == 8'd1 << words[9][15:13], "R7 rx len", 64'(rx_len), 64'(8'd1 << words[9][15:13]));
    chk(tx_len == 8'd1 << words[11][15:13], "R7 tx len", 64'(tx_len), 64'(8'd1 << words[11][15:13]));
    chk(rx_on == !words[0][0], "R8 rx enable", 64'(rx_on), 64'(!words[0][0]));
    chk(tx_on == !words[0][1], "R8 tx enable", 64'(tx_on), 64'(!words[0][1]));
    @(negedge clk);
    chk(done == 0, "R9 done is one cycle", 64'(done), 64'd0);
    chk(idon == 1, "R10 idon holds", 64'(idon), 64'd1);
    if (inject) begin
      int extra = 0;
      for (int k = 0; k < 15; k++) begin
        if (sram_rd || done) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R11 no restart after ignored request", 64'(extra), 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && sram_rd == 0, "R12 reset idle", {busy, done, sram_rd}, 64'd0);
    chk(idon == 0 && misalign == 0, "R12 reset flags", {idon, misalign}, 64'd0);
    chk(rx_on == 0 && tx_on == 0, "R12 reset enables", {rx_on, tx_on}, 64'd0);
    chk(rx_len == 8'd1 && tx_len == 8'd1, "R12 reset lengths", {rx_len, tx_len}, 64'h0101);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      fill(r);
      run_load(24'h010000 * r + 24'h000100 + 24'(r * 64), 1'b0);
      repeat (2) @(negedge clk);
    end
    fill(3);
    run_load(24'h000333, 1'b0);
    fill(5);
    run_load(24'h0a2000, 1'b1);
    fill(6);
    run_load(24'h004444, 1'b0);
    chk(misalign == 0, "R3 misalign cleared by even start", 64'(misalign), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule